// File: doc/BRIEF.md
# Serial Port Register Bank

This block is the software-visible front end of a byte-oriented serial port. A host reaches it over a 32-bit register bus with byte enables. It holds six control and status words and two 16-entry byte queues. Bytes that software writes into the transmit port leave on a valid/ready byte stream. Bytes arriving on a second valid/ready stream are queued until software reads them from the receive port. The line itself is assumed to run as fixed 8N1 with instant transfer, so no bit timing, baud division, DMA or flow control is modelled. The baud and line words are storage only.

A level interrupt is raised whenever an enabled interrupt-status flag is set. Status flags are sticky. The hardware sets them from the queue states, and software clears them by writing zeros. The bus is word-addressed: `bus_addr` is the byte offset divided by four. The byte lanes are big-endian, so `bus_be[3]` selects bits 31:24, which is byte offset 0.

On the transmit stream, a byte is transferred in each cycle where `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, `tx_valid` and `tx_data` hold. On the receive stream, `rx_ready` is low exactly when the receive queue is full. A byte presented while `rx_ready` is low is not taken, and the source keeps it.

Top module: `sio_regbank`

## Requirements
- R1: While reset is held, the registers read as follows: line word (index 0) is 0x40000000, baud word (index 5) is 0x03FF0000, and every other word is 0. Both queues are empty, which shows as `tx_valid`=0 and `rx_ready`=1, and `irq` is 0.
- R2: A write replaces only the enabled byte lanes (`bus_be[i]` covers bits 8i+7:8i), and the stored result keeps only these writable bits:
  - line word (index 0): 0xE17F0000
  - interrupt-enable word (index 2): 0x000F0000
  - queue-control word (index 4): 0x001F0000
  - baud word (index 5): 0x03FF0000

  The line-status word (index 1) always reads 0 and ignores writes. Reads return zero in byte lanes that are not enabled.
- R3: In the interrupt-status word (index 3), bit 16 becomes set one cycle after the receive queue holds data, and bit 17 becomes set one cycle after the transmit queue is empty. Both bits stay set until they are cleared.
- R4: A write to the interrupt-status word ANDs each enabled lane with the written data, keeping only bits 18:16. A flag whose set condition is present in the same cycle stays set.
- R5: `irq` is high exactly when (status AND enable) is nonzero over bits 18:16, and it reflects a status or enable write from the cycle after that write. Enable bit 19 is stored but has no effect.
- R6: After a write to the queue-control word, the receive queue is flushed if bits 16 and 17 of the new value are both set. The transmit queue is flushed if bits 16 and 18 are both set.
- R7: A read of the receive port (index 12) with `bus_be[3]` set pops one byte and returns it in bits 31:24. A read without that lane does not pop, and a read while the queue is empty returns 0.
- R8: A write to the transmit port (index 8) pushes `bus_wdata[31:24]` only when `bus_be[3]` is set. Reading the transmit port returns 0, and writes to the receive port are ignored.
- R9: The transmit stream presents bytes in the order they were pushed. It keeps `tx_data` stable while `tx_valid` is high and `tx_ready` is low.
- R10: Each queue holds 16 bytes. A push to a full transmit queue is dropped, and `rx_ready` is low exactly while the receive queue is full.
- R11: Writes to unmapped word indices (6, 7, 9-11 and 13-63) are ignored, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Word index (byte offset / 4) |
| bus_be | input | 4 | Byte enables, bit 3 = bits 31:24 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| tx_valid | output | 1 | Transmit byte available |
| tx_ready | input | 1 | Sink accepts transmit byte |
| tx_data | output | 8 | Transmit byte |
| rx_valid | input | 1 | Receive byte offered |
| rx_ready | output | 1 | Receive queue has room |
| rx_data | input | 8 | Receive byte |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that a host access lasts exactly one cycle and that at most one access is in flight. They also assume that the receive source does not depend on a combinational path from `bus_rdata`. The stimulus drives a single one-cycle access at a time and holds all bus inputs low between accesses. The receive stream is only offered bytes while bus traffic is idle. The transmit sink holds `tx_ready` low unless the bench is draining on purpose, so the stall-stability property sees real back-pressure.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned LANES  = DATA_W / 8;
  localparam int unsigned IDX_W  = 6;

  localparam logic [IDX_W-1:0] IDX_LINE  = 6'd0;
  localparam logic [IDX_W-1:0] IDX_LSTAT = 6'd1;
  localparam logic [IDX_W-1:0] IDX_IEN   = 6'd2;
  localparam logic [IDX_W-1:0] IDX_ISTAT = 6'd3;
  localparam logic [IDX_W-1:0] IDX_FCTL  = 6'd4;
  localparam logic [IDX_W-1:0] IDX_BAUD  = 6'd5;
  localparam logic [IDX_W-1:0] IDX_TXP   = 6'd8;
  localparam logic [IDX_W-1:0] IDX_RXP   = 6'd12;

  localparam logic [DATA_W-1:0] MASK_LINE  = 32'hE17F_0000;
  localparam logic [DATA_W-1:0] MASK_IEN   = 32'h000F_0000;
  localparam logic [DATA_W-1:0] MASK_ISTAT = 32'h0007_0000;
  localparam logic [DATA_W-1:0] MASK_FCTL  = 32'h001F_0000;
  localparam logic [DATA_W-1:0] MASK_BAUD  = 32'h03FF_0000;
  localparam logic [DATA_W-1:0] RST_LINE   = 32'h4000_0000;
  localparam logic [DATA_W-1:0] RST_BAUD   = 32'h03FF_0000;
  localparam logic [DATA_W-1:0] IRQ_SRC    = 32'h0007_0000;

  localparam int unsigned ST_RX  = 16;
  localparam int unsigned ST_TX  = 17;
  localparam int unsigned FC_EN  = 16;
  localparam int unsigned FC_RX  = 17;
  localparam int unsigned FC_TX  = 18;

  function automatic logic [DATA_W-1:0] lane_merge(
    input logic [DATA_W-1:0] old_v, input logic [DATA_W-1:0] new_v,
    input logic [LANES-1:0] be, input logic [DATA_W-1:0] mask);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < LANES; i++)
      r[8*i +: 8] = be[i] ? new_v[8*i +: 8] : old_v[8*i +: 8];
    return r & mask;
  endfunction

  function automatic logic [DATA_W-1:0] lane_and(
    input logic [DATA_W-1:0] old_v, input logic [DATA_W-1:0] new_v,
    input logic [LANES-1:0] be);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < LANES; i++)
      r[8*i +: 8] = be[i] ? (old_v[8*i +: 8] & new_v[8*i +: 8]) : old_v[8*i +: 8];
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] lane_keep(
    input logic [DATA_W-1:0] v, input logic [LANES-1:0] be);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < LANES; i++)
      r[8*i +: 8] = be[i] ? v[8*i +: 8] : 8'h00;
    return r;
  endfunction
endpackage

// File: rtl/sio_byte_fifo.sv
module sio_byte_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam logic [AW:0] CNT_FULL = (AW+1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CNT_FULL);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      cnt <= cnt + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> full);

  // R6
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
endmodule

// File: rtl/sio_csr.sv
module sio_csr
  import sio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  widx,
  input  logic [LANES-1:0]  be,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rx_has_data,
  input  logic              tx_is_empty,
  output logic [DATA_W-1:0] line_q,
  output logic [DATA_W-1:0] ien_q,
  output logic [DATA_W-1:0] ist_q,
  output logic [DATA_W-1:0] fctl_q,
  output logic [DATA_W-1:0] baud_q,
  output logic              irq,
  output logic              flush_rx,
  output logic              flush_tx
);
  logic [DATA_W-1:0] fctl_nx, ist_nx;
  logic              fctl_wr;

  assign fctl_wr  = wr_en && (widx == IDX_FCTL);
  assign fctl_nx  = lane_merge(fctl_q, wdata, be, MASK_FCTL);
  assign flush_rx = fctl_wr && fctl_nx[FC_EN] && fctl_nx[FC_RX];
  assign flush_tx = fctl_wr && fctl_nx[FC_EN] && fctl_nx[FC_TX];

  always_comb begin
    ist_nx = ist_q;
    if (wr_en && widx == IDX_ISTAT)
      ist_nx = lane_and(ist_q, wdata, be) & MASK_ISTAT;
    if (rx_has_data) ist_nx[ST_RX] = 1'b1;
    if (tx_is_empty) ist_nx[ST_TX] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q <= RST_LINE;
      ien_q  <= '0;
      ist_q  <= '0;
      fctl_q <= '0;
      baud_q <= RST_BAUD;
    end else begin
      ist_q <= ist_nx;
      if (wr_en) begin
        unique case (widx)
          IDX_LINE: line_q <= lane_merge(line_q, wdata, be, MASK_LINE);
          IDX_IEN:  ien_q  <= lane_merge(ien_q, wdata, be, MASK_IEN);
          IDX_FCTL: fctl_q <= fctl_nx;
          IDX_BAUD: baud_q <= lane_merge(baud_q, wdata, be, MASK_BAUD);
          default: ;
        endcase
      end
    end
  end

  assign irq = |(ist_q & ien_q & IRQ_SRC);

  // R3
  rx_flag_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_has_data |=> ist_q[ST_RX]);

  // R3
  tx_flag_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_is_empty |=> ist_q[ST_TX]);
endmodule

// File: rtl/sio_regbank.sv
module sio_regbank
  import sio_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [IDX_W-1:0]  bus_addr,
  input  logic [LANES-1:0]  bus_be,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data,
  output logic              irq
);
  logic [DATA_W-1:0] line_q, ien_q, ist_q, fctl_q, baud_q, raw;
  logic              wr_en, rd_en, flush_rx, flush_tx;
  logic              tx_empty, tx_full, rx_empty, rx_full;
  logic              tx_push, rx_pop;
  logic [7:0]        rx_head;

  assign wr_en   = bus_sel && bus_wr;
  assign rd_en   = bus_sel && !bus_wr;
  assign tx_push = wr_en && (bus_addr == IDX_TXP) && bus_be[LANES-1];
  assign rx_pop  = rd_en && (bus_addr == IDX_RXP) && bus_be[LANES-1];

  sio_csr u_csr (
    .clk, .rst_n, .wr_en, .widx(bus_addr), .be(bus_be), .wdata(bus_wdata),
    .rx_has_data(!rx_empty), .tx_is_empty(tx_empty),
    .line_q, .ien_q, .ist_q, .fctl_q, .baud_q, .irq, .flush_rx, .flush_tx
  );

  sio_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_txq (
    .clk, .rst_n, .flush(flush_tx), .push(tx_push),
    .din(bus_wdata[DATA_W-1 -: 8]), .pop(tx_valid && tx_ready),
    .dout(tx_data), .empty(tx_empty), .full(tx_full)
  );

  sio_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_rxq (
    .clk, .rst_n, .flush(flush_rx), .push(rx_valid && rx_ready),
    .din(rx_data), .pop(rx_pop),
    .dout(rx_head), .empty(rx_empty), .full(rx_full)
  );

  assign tx_valid = !tx_empty;
  assign rx_ready = !rx_full;

  always_comb begin
    unique case (bus_addr)
      IDX_LINE:  raw = line_q;
      IDX_IEN:   raw = ien_q;
      IDX_ISTAT: raw = ist_q;
      IDX_FCTL:  raw = fctl_q;
      IDX_BAUD:  raw = baud_q;
      IDX_RXP:   raw = rx_empty ? '0 : {rx_head, {(DATA_W-8){1'b0}}};
      default:   raw = '0;
    endcase
    bus_rdata = rd_en ? lane_keep(raw, bus_be) : '0;
  end

  // R7
  empty_pop_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && bus_addr == IDX_RXP && rx_empty) |-> (bus_rdata == '0));

  // R9
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !flush_tx) |=> (tx_valid && $stable(tx_data)));

  // R10
  rx_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !rx_pop && !flush_rx) |=> !rx_ready);
endmodule

// File: tb/sio_regbank_bench.sv
module sio_regbank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        tx_valid, tx_ready = 1'b0, rx_valid = 1'b0, rx_ready, irq;
  logic [7:0]  tx_data, rx_data = '0;
  int total = 0, bad = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  sio_regbank u_sio_regbank (
    .clk, .rst_n, .bus_sel, .bus_wr, .bus_addr, .bus_be, .bus_wdata, .bus_rdata,
    .tx_valid, .tx_ready, .tx_data, .rx_valid, .rx_ready, .rx_data, .irq
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [3:0] b, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_be = b; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 0; bus_wr = 0; bus_be = '0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [3:0] b, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a; bus_be = b;
    #2 d = bus_rdata;
    @(posedge clk); #1;
    bus_sel = 0; bus_be = '0;
  endtask

  task automatic rx_offer(input logic [7:0] b, output logic rdy);
    @(negedge clk);
    rx_valid = 1; rx_data = b;
    #2 rdy = rx_ready;
    @(posedge clk); #1;
    rx_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [31:0] lanes_of(input logic [3:0] b);
    logic [31:0] r = '0;
    for (int i = 0; i < 4; i++) if (b[i]) r[8*i +: 8] = 8'hFF;
    return r;
  endfunction

  task automatic clear_queues();
    wr(6'd4, 4'hF, 32'h0007_0000);
    wr(6'd4, 4'hF, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic rdy;
    logic [5:0]  ridx [5] = '{6'd0, 6'd1, 6'd2, 6'd4, 6'd5};
    logic [31:0] rmsk [5] = '{32'hE17F0000, 32'h0, 32'h000F0000, 32'h001F0000, 32'h03FF0000};

    // R1 reset state, sampled while reset is held
    repeat (2) @(posedge clk);
    #1 bus_sel = 1; bus_be = 4'hF;
    bus_addr = 6'd0; #1 chk("R1 line", bus_rdata, 32'h40000000);
    bus_addr = 6'd5; #1 chk("R1 baud", bus_rdata, 32'h03FF0000);
    bus_addr = 6'd2; #1 chk("R1 ien", bus_rdata, 32'h0);
    bus_addr = 6'd3; #1 chk("R1 istat", bus_rdata, 32'h0);
    bus_addr = 6'd4; #1 chk("R1 fctl", bus_rdata, 32'h0);
    chk("R1 tx_valid", {31'b0, tx_valid}, 32'h0);
    chk("R1 rx_ready", {31'b0, rx_ready}, 32'h1);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    bus_sel = 0; bus_be = '0;
    @(negedge clk); rst_n = 1;
    idle(2);

    // R3 transmit-empty flag appears after reset
    rd(6'd3, 4'hF, d); chk("R3 tx empty flag", d, 32'h00020000);

    // R2 lane and mask sweep
    for (int r = 0; r < 5; r++)
      for (int b = 0; b < 16; b++) begin
        wr(ridx[r], 4'hF, 32'h0);
        wr(ridx[r], 4'(b), 32'hFFFFFFFF);
        rd(ridx[r], 4'hF, d);
        chk($sformatf("R2 idx%0d be%0h", ridx[r], b), d, rmsk[r] & lanes_of(4'(b)));
      end
    rd(6'd0, 4'b1000, d); chk("R2 partial read lane", d, 32'hE1000000);
    for (int r = 0; r < 5; r++) wr(ridx[r], 4'hF, 32'h0);

    // R11 unmapped offsets
    wr(6'd6, 4'hF, 32'hFFFFFFFF); rd(6'd6, 4'hF, d); chk("R11 idx6", d, 0);
    wr(6'd7, 4'hF, 32'hFFFFFFFF); rd(6'd7, 4'hF, d); chk("R11 idx7", d, 0);
    wr(6'd16, 4'hF, 32'hFFFFFFFF); rd(6'd16, 4'hF, d); chk("R11 idx16", d, 0);
    wr(6'd63, 4'hF, 32'hFFFFFFFF); rd(6'd63, 4'hF, d); chk("R11 idx63", d, 0);
    rd(6'd0, 4'hF, d); chk("R11 line untouched", d, 32'h0);

    // R8 push gating and port isolation
    wr(6'd8, 4'b0111, 32'hAABBCCDD);
    chk("R8 no push without MS lane", {31'b0, tx_valid}, 0);
    wr(6'd12, 4'hF, 32'h55000000);
    rd(6'd12, 4'hF, d); chk("R8 rx port write ignored", d, 0);

    // R10 fill transmit queue past depth
    for (int i = 0; i < 17; i++) wr(6'd8, 4'b1000, {8'(i*7+3), 24'h0});
    chk("R8 push seen", {31'b0, tx_valid}, 1);
    rd(6'd8, 4'hF, d); chk("R8 tx port reads zero", d, 0);
    wr(6'd3, 4'hF, 32'h0);
    rd(6'd3, 4'hF, d); chk("R4 tx flag cleared while queue full", d, 0);
    // R9 stall keeps the head byte
    idle(3); chk("R9 head held", {24'b0, tx_data}, 32'd3);
    @(negedge clk); tx_ready = 1;
    for (int i = 0; i < 16; i++) begin
      #2;
      chk($sformatf("R9 tx valid %0d", i), {31'b0, tx_valid}, 1);
      chk($sformatf("R9 tx order %0d", i), {24'b0, tx_data}, 32'(8'(i*7+3)));
      @(negedge clk);
    end
    #2 chk("R10 17th push dropped", {31'b0, tx_valid}, 0);
    tx_ready = 0;
    idle(2);
    rd(6'd3, 4'hF, d); chk("R3 tx flag re-set", d, 32'h00020000);

    // R10 receive queue fill and back-pressure
    for (int i = 0; i < 17; i++) begin
      rx_offer(8'(i*5+1), rdy);
      chk($sformatf("R10 rx_ready %0d", i), {31'b0, rdy}, (i < 16) ? 1 : 0);
    end
    idle(2);
    rd(6'd3, 4'hF, d); chk("R3 rx flag", d, 32'h00030000);
    // R7 pop rules
    rd(6'd12, 4'b0111, d); chk("R7 no pop without MS lane", d, 0);
    rd(6'd12, 4'b1000, d); chk("R7 pop 0", d, {8'd1, 24'h0});
    for (int i = 1; i < 16; i++) begin
      rd(6'd12, 4'hF, d); chk($sformatf("R7 pop %0d", i), d, {8'(i*5+1), 24'h0});
    end
    rd(6'd12, 4'hF, d); chk("R7 empty read", d, 0);

    // R4 write-to-clear
    wr(6'd3, 4'hF, 32'hFFFEFFFF);
    rd(6'd3, 4'hF, d); chk("R4 rx flag cleared", d, 32'h00020000);
    wr(6'd3, 4'b1011, 32'h0);
    rd(6'd3, 4'hF, d); chk("R4 disabled lane kept", d, 32'h00020000);
    wr(6'd3, 4'b0100, 32'h0);
    rd(6'd3, 4'hF, d); chk("R4 set condition wins", d, 32'h00020000);

    // R5 interrupt over status x enable combinations
    for (int s = 0; s < 4; s++) begin
      clear_queues();
      if (s[0]) rx_offer(8'h77, rdy);
      if (!s[1]) wr(6'd8, 4'b1000, 32'h99000000);
      idle(3);
      wr(6'd3, 4'hF, 32'(s) << 16);
      rd(6'd3, 4'hF, d); chk($sformatf("R3 status setup %0d", s), d, 32'(s) << 16);
      for (int e = 0; e < 16; e++) begin
        wr(6'd2, 4'hF, 32'(e) << 16);
        chk($sformatf("R5 irq s%0d e%0d", s, e), {31'b0, irq},
            32'((s & e & 3) != 0));
      end
      wr(6'd2, 4'hF, 32'h0);
      #1 chk($sformatf("R5 irq off s%0d", s), {31'b0, irq}, 0);
    end

    // R6 flush gating sweep
    for (int c = 0; c < 8; c++) begin
      clear_queues();
      rx_offer(8'h3C, rdy);
      wr(6'd8, 4'b1000, 32'hC3000000);
      wr(6'd4, 4'hF, 32'(c) << 16);
      chk($sformatf("R6 tx c%0d", c), {31'b0, tx_valid}, 32'(!(c[0] && c[2])));
      rd(6'd4, 4'hF, d); chk($sformatf("R6 fctl c%0d", c), d, 32'(c) << 16);
      rd(6'd12, 4'b1000, d);
      chk($sformatf("R6 rx c%0d", c), d, (c[0] && c[1]) ? 32'h0 : 32'h3C000000);
    end
    clear_queues();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule